// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus whose data line is stuck low because a target device was interrupted partway through a byte. When a start pulse arrives and the block is idle, it takes control of both bus pins and leaves the data line released. It then clocks the bus until the target finishes shifting out whatever it was sending and lets go of the data line.

After the clock train, the block drives a STOP condition step by step, using only forced pin levels. On the last clock of the sequence it samples the data line. It then hands the pins back to the normal engine and reports in a single cycle whether the bus is free.

Every step of the sequence lasts one delay unit. A delay unit is `HALF_CYCLES` system clocks.

States and transitions:
- `ST_IDLE` goes to `ST_CLK_HIGH` on a start pulse.
- `ST_CLK_HIGH` goes to `ST_CLK_LOW` when the unit expires.
- `ST_CLK_LOW` goes back to `ST_CLK_HIGH` while pulses remain. After the last pulse it goes to `ST_STOP_PREP`.
- The STOP steps then follow in order: `ST_STOP_PREP`, `ST_STOP_SETUP`, `ST_STOP_HOLD`, `ST_STOP_RELEASE`.
- `ST_STOP_RELEASE` goes to `ST_REPORT` and samples the data line on the way.
- `ST_REPORT` goes to `ST_IDLE` after one cycle.

Top module: `i2c_bus_unlock`

## Requirements
- R1: After reset the override enable, busy, done and fail outputs are 0. While the override is off, both forced levels are 1 (released).
- R2: A start pulse accepted in idle sets busy and override enable from the next cycle. The first active cycle drives SCL high and SDA high.
- R3: Exactly `PULSES` (default 9) falling edges of SCL are driven while busy, and SDA stays forced high for all of them.
- R4: Each SCL high and low phase lasts `HALF_CYCLES` clocks. The whole active sequence lasts (2·`PULSES`+4)·`HALF_CYCLES` clocks.
- R5: After the last low phase the block drives four steps of one unit each, in this order as (SCL,SDA): (0,1), (0,0), (1,0), (1,1). SDA therefore falls only while SCL is low. Exactly one rising edge of SDA occurs while SCL is high.
- R6: The data line is sampled on the last clock of the final step. The result is fail=1 if it reads low and fail=0 if it reads high.
- R7: In the cycle after the last busy cycle, done is 1 for exactly one cycle and override enable and busy are 0. The fail output changes only on that cycle's edge or when a new run starts, where it is cleared. It holds in between.
- R8: A start pulse while the sequence is active has no effect on the waveform, its length or the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin recovery (acted on only when idle) |
| sda_in_i | input | 1 | Sampled level of the SDA line |
| ovr_en_o | output | 1 | Pin override enable: pins follow the forced levels |
| scl_o | output | 1 | Forced SCL level (1 = released) |
| sda_o | output | 1 | Forced SDA level (1 = released) |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Bus still held low at the end (valid from done, held) |

## Verification
Some internal faults appear only on the SCL level: a timer that miscounts, or a pulse counter that ends early or late. They show as an SCL phase whose length is not one or three units, a wrong count of SCL falling edges, or a wrong active length, all visible within one run. A wrong step order in the STOP part shows within the last four units. It appears as SDA falling while SCL is high, or as a missing or doubled SDA rise while SCL is high. A wrong sampling point or polarity shows on the single done cycle. The bench separates these cases with a target model that releases SDA after a chosen number of clock falls.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_HIGH,
        ST_CLK_LOW,
        ST_STOP_PREP,
        ST_STOP_SETUP,
        ST_STOP_HOLD,
        ST_STOP_RELEASE,
        ST_REPORT
    } unlock_state_t;

    // Pin drive bundle decoded from the state
    typedef struct packed {
        logic ovr;
        logic scl;
        logic sda;
        logic busy;
        logic done;
    } pin_drive_t;

endpackage

// File: rtl/unlock_timer.sv
module unlock_timer #(
    parameter int HALF_CYCLES = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    // Counts clocks inside one step; restarts at every step boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/unlock_pulse_cnt.sv
module unlock_pulse_cnt #(
    parameter int PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int PW = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [PW-1:0] FINAL = PW'(PULSES - 1);

    logic [PW-1:0] done_pulses;

    assign last = (done_pulses == FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_pulses <= '0;
        end else if (clear) begin
            done_pulses <= '0;
        end else if (step) begin
            done_pulses <= done_pulses + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_unlock.sv
module i2c_bus_unlock #(
    parameter int HALF_CYCLES = 625,
    parameter int PULSES      = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_in_i,
    output logic ovr_en_o,
    output logic scl_o,
    output logic sda_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o
);
    import unlock_pkg::*;

    unlock_state_t state_q, state_d;
    pin_drive_t    drive;
    logic          unit_end;
    logic          pulses_last;
    logic          accept;
    logic          pulse_step;
    logic          fail_q;

    assign accept     = start_i && (state_q == ST_IDLE);
    assign pulse_step = (state_q == ST_CLK_LOW) && unit_end && !pulses_last;

    unlock_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (drive.busy),
        .expire (unit_end)
    );

    unlock_pulse_cnt #(.PULSES(PULSES)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (pulse_step),
        .last  (pulses_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result register: cleared on a new run, captured at the end of the final step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else if (accept) begin
            fail_q <= 1'b0;
        end else if (state_q == ST_STOP_RELEASE && unit_end) begin
            fail_q <= !sda_in_i;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (start_i)  state_d = ST_CLK_HIGH;
            ST_CLK_HIGH:     if (unit_end) state_d = ST_CLK_LOW;
            ST_CLK_LOW:      if (unit_end) state_d = pulses_last ? ST_STOP_PREP : ST_CLK_HIGH;
            ST_STOP_PREP:    if (unit_end) state_d = ST_STOP_SETUP;
            ST_STOP_SETUP:   if (unit_end) state_d = ST_STOP_HOLD;
            ST_STOP_HOLD:    if (unit_end) state_d = ST_STOP_RELEASE;
            ST_STOP_RELEASE: if (unit_end) state_d = ST_REPORT;
            ST_REPORT:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Output decode: fields are {ovr, scl, sda, busy, done}
    always_comb begin
        unique case (state_q)
            ST_IDLE:         drive = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            ST_CLK_HIGH:     drive = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_CLK_LOW:      drive = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            ST_STOP_PREP:    drive = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            ST_STOP_SETUP:   drive = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            ST_STOP_HOLD:    drive = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
            ST_STOP_RELEASE: drive = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            ST_REPORT:       drive = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
            default:         drive = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
        endcase
    end

    assign ovr_en_o = drive.ovr;
    assign scl_o    = drive.scl;
    assign sda_o    = drive.sda;
    assign busy_o   = drive.busy;
    assign done_o   = drive.done;
    assign fail_o   = fail_q;
endmodule

// File: rtl/unlock_checker.sv
module unlock_checker #(
    parameter int HALF_CYCLES = 625,
    parameter int PULSES      = 9
) (
    input logic clk,
    input logic rst_n,
    input logic ovr_en_o,
    input logic scl_o,
    input logic sda_o,
    input logic busy_o,
    input logic done_o,
    input logic fail_o
);
    localparam int EXP_LEN = (2 * PULSES + 4) * HALF_CYCLES;

    int active_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_len <= 0;
        end else if (busy_o) begin
            active_len <= active_len + 1;
        end else begin
            active_len <= 0;
        end
    end

    AST_RELEASED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_en_o |-> (scl_o && sda_o)); // R1

    AST_OVR_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en_o == busy_o); // R2

    AST_ACTIVE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (active_len == EXP_LEN)); // R4

    AST_SDA_FALLS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_o) |-> !scl_o); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_PINS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ovr_en_o && !busy_o)); // R7

    AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fail_o) |-> (done_o || $rose(busy_o))); // R7
endmodule

bind i2c_bus_unlock unlock_checker #(
    .HALF_CYCLES (HALF_CYCLES),
    .PULSES      (PULSES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovr_en_o (ovr_en_o),
    .scl_o    (scl_o),
    .sda_o    (sda_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fail_o   (fail_o)
);

// File: tb/i2c_bus_unlock_test.sv
module i2c_bus_unlock_test;
    localparam int H   = 4;
    localparam int NP  = 9;
    localparam int LEN = (2 * NP + 4) * H;

    localparam int VEC_N = 6;
    // release after N falling SCL edges seen by the stuck target; expected fail
    localparam int REL  [VEC_N] = '{0, 1, 5, 8, 9, 10};
    localparam bit EXPF [VEC_N] = '{0, 0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic hold = 1'b0;
    logic sda_line;
    logic ovr_en, scl, sda, busy, done, fail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Monitor state
    bit mon_on = 1'b0;
    int rel_after;
    int busy_cycles, falls, sda_low, stops, starts, done_cnt, phase_bad, runlen;
    bit done_fail;
    logic prev_scl = 1'b1, prev_sda = 1'b1, prev_busy = 1'b0;

    assign sda_line = sda & ~hold;

    always #4 clk = ~clk;   // 125 MHz

    i2c_bus_unlock #(.HALF_CYCLES(H), .PULSES(NP)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .sda_in_i (sda_line),
        .ovr_en_o (ovr_en),
        .scl_o    (scl),
        .sda_o    (sda),
        .busy_o   (busy),
        .done_o   (done),
        .fail_o   (fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busy_cycles++;
            if (done) begin
                done_cnt++;
                done_fail = fail;
            end
            if (busy && !sda) sda_low++;
            if (prev_scl && !scl) begin
                falls++;
                if (falls >= rel_after) hold = 1'b0;
            end
            if (prev_scl && scl && !prev_sda && sda) stops++;
            if (prev_scl && scl && prev_sda && !sda) starts++;
            if (busy && !prev_busy) begin
                runlen = 1;
            end else if (busy && scl != prev_scl) begin
                if (runlen != H && runlen != 3 * H) phase_bad++;
                runlen = 1;
            end else if (busy) begin
                runlen++;
            end
        end
        prev_scl  = scl;
        prev_sda  = sda;
        prev_busy = busy;
    end

    task automatic run_seq(input int rel, input bit expf, input bit inject);
        rel_after   = rel;
        busy_cycles = 0; falls = 0; sda_low = 0; stops = 0; starts = 0;
        done_cnt = 0; phase_bad = 0; runlen = 0; done_fail = 1'b0;
        hold   = (rel > 0);
        mon_on = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first active cycle
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 override after start", int'(ovr_en), 1);
        chk("R2 first levels scl,sda", int'({scl, sda}), 3);
        chk("R7 fail cleared on new run", int'(fail), 0);
        for (int i = 0; i < LEN + 20; i++) begin
            @(negedge clk);
            start = (inject && (i == 20 || i == LEN - 2)) ? 1'b1 : 1'b0;  // R8
        end
        start  = 1'b0;
        mon_on = 1'b0;
        chk("R4 active length", busy_cycles, LEN);
        chk("R4 phase lengths", phase_bad, 0);
        chk("R3 scl falling edges", falls, NP);
        chk("R3 R5 sda low cycles", sda_low, 2 * H);
        chk("R5 stop conditions", stops, 1);
        chk("R5 start conditions", starts, 0);
        chk("R7 done pulses", done_cnt, 1);
        chk("R6 result at done", int'(done_fail), int'(expf));
        chk("R7 result held", int'(fail), int'(expf));
        chk("R7 override released", int'(ovr_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 override", int'(ovr_en), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 released levels", int'({scl, sda}), 3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'({ovr_en, busy, done}), 0);

        for (int v = 0; v < VEC_N; v++) begin
            run_seq(REL[v], EXPF[v], 1'b0);
        end

        // R8: start pulses during an active run are ignored (also clears prior fail)
        run_seq(0, 1'b0, 1'b1);
        // R6: fail again, then confirm it persists across idle cycles
        run_seq(12, 1'b1, 1'b1);
        repeat (10) @(negedge clk);
        chk("R7 fail held in idle", int'(fail), 1);
        chk("R8 no restart", int'(busy), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule